// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order pipeline (fetch, decode with register read, execute, memory access, write-back). Each cycle it looks at the register numbers and control bits held in the pipeline registers between stages. From them it picks the source of each ALU operand. It also decides whether the front end must hold for a cycle while a bubble enters the execute stage, and whether the two youngest instructions must be squashed after a branch resolves taken.

ALU results are passed straight to the next instruction's operand, so back-to-back dependent ALU operations run without a pause. A load's data only exists after the memory stage. An instruction that needs that data in the very next cycle must therefore wait one cycle. Branches are assumed not taken, and fetch continues in order. The outcome is known in the execute stage, and a taken branch throws away the instructions in the decode and execute slots. All outputs are combinational from the inputs. The clock and reset only time the unit's cycle properties.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand selects the memory-stage result (select code 2'b10) when `memRegWrite` is 1, `memRd` is nonzero, and `memRd` equals that operand's execute-stage source register (`exRs` for operand A, `exRt` for operand B).
- R2: An operand selects the write-back result (select code 2'b01) when `wbRegWrite` is 1, `wbRd` is nonzero, `wbRd` equals its source register, and R1 does not apply to it.
- R3: When both the memory-stage and write-back destinations match an operand's source, the memory-stage result (2'b10) is chosen.
- R4: A destination of register 0, or a deasserted write enable, never produces a forward. The select stays at 2'b00 in that case.
- R5: With no qualifying match, the select is 2'b00 (register-file value). With all inputs zero, every output is 0.
- R6: When `exMemRead` is 1 and `exRt` equals `idRs` or `idRt`, `holdFront` and `idExBubble` are both 1 and `ifIdFlush` is 0.
- R7: When `exMemRead` is 0, `holdFront` is 0, even if register numbers match.
- R8: When `exBranchTaken` is 1, `ifIdFlush` and `idExBubble` are 1.
- R9: A taken branch wins over a load-use stall in the same cycle: `holdFront` is 0 and `ifIdFlush` is 1.
- R10: Operands A and B are selected independently. In the same cycle one operand may take the memory-stage result while the other takes the write-back result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, times the cycle properties |
| rstN | input | 1 | Active-low reset, disables the properties |
| idRs | input | 5 | First source register of the instruction in the decode slot |
| idRt | input | 5 | Second source register of the instruction in the decode slot |
| exRs | input | 5 | First source register of the instruction in execute |
| exRt | input | 5 | Second source register in execute; load destination |
| exMemRead | input | 1 | Instruction in execute is a load |
| exBranchTaken | input | 1 | Branch in execute resolved taken |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memRd | input | 5 | Memory-stage destination register |
| wbRegWrite | input | 1 | Write-back instruction writes a register |
| wbRd | input | 5 | Write-back destination register |
| fwdSelA | output | 2 | Operand A source: 00 file, 10 memory stage, 01 write-back |
| fwdSelB | output | 2 | Operand B source, same coding |
| holdFront | output | 1 | Hold PC and the fetch/decode register |
| idExBubble | output | 1 | Zero the control bits entering execute |
| ifIdFlush | output | 1 | Squash the instruction in the fetch/decode register |

## Verification
On every cycle, the properties check three things. A memory-stage select is always backed by a live, nonzero, matching destination. The memory-stage result wins a double match. Register 0 is never forwarded. Stall and flush also keep to their rules: a hold always brings a bubble, a hold never appears without a load in execute, and a taken branch always flushes and never holds. Only the bench's scenarios can show the full selection table against an independent model. That includes the write-back-only case and the two operands taking different sources in one cycle. It also includes the exact stall condition over both decode sources, under long random runs with small register numbers that force frequent matches.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  // datapath -> control
  typedef struct packed {
    logic loadDep;
  } hazHits_t;

  // control -> top
  typedef struct packed {
    logic holdFront;
    logic bubble;
    logic flush;
  } hazStrobes_t;

endpackage

// File: rtl/hazard_fwd_path.sv
module hazard_fwd_path
  import hazard_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] exSrc [NUM_SRC],
  input  logic [REG_W-1:0] idSrc [NUM_SRC],
  input  logic [REG_W-1:0] loadDst,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbRd,
  output fwdSel_e          fwdSel [NUM_SRC],
  output hazHits_t         hits
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] depVec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic memHit, wbHit;

    assign memHit = memRegWrite && (memRd != ZERO_REG) && (memRd == exSrc[g]);
    assign wbHit  = wbRegWrite  && (wbRd  != ZERO_REG) && (wbRd  == exSrc[g]);

    always_comb begin
      if (memHit)     fwdSel[g] = FWD_MEM;
      else if (wbHit) fwdSel[g] = FWD_WB;
      else            fwdSel[g] = FWD_RF;
    end

    assign depVec[g] = (loadDst == idSrc[g]);

    // R1
    mem_sel_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fwdSel[g] == FWD_MEM) |-> (memRegWrite && memRd != ZERO_REG && memRd == exSrc[g]));

    // R3
    mem_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (memRegWrite && wbRegWrite && memRd == exSrc[g] && wbRd == exSrc[g] && memRd != ZERO_REG)
        |-> (fwdSel[g] == FWD_MEM));

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
      (exSrc[g] == ZERO_REG) |-> (fwdSel[g] == FWD_RF));

    // R5
    sel_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(fwdSel[g]));
  end

  assign hits.loadDep = |depVec;

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hazHits_t    hits,
  input  logic        exMemRead,
  input  logic        exBranchTaken,
  output hazStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (exBranchTaken) begin
      strobes.flush  = 1'b1;
      strobes.bubble = 1'b1;
    end else if (exMemRead && hits.loadDep) begin
      strobes.holdFront = 1'b1;
      strobes.bubble    = 1'b1;
    end
  end

  // R6
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdFront |-> (strobes.bubble && !strobes.flush));

  // R7
  hold_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRead |-> !strobes.holdFront);

  // R8
  branch_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    exBranchTaken |-> (strobes.flush && strobes.bubble));

  // R9
  flush_over_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    exBranchTaken |-> !strobes.holdFront);

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic             exMemRead,
  input  logic             exBranchTaken,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbRd,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             holdFront,
  output logic             idExBubble,
  output logic             ifIdFlush
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] exSrc [NUM_SRC];
  logic [REG_W-1:0] idSrc [NUM_SRC];
  fwdSel_e          selArr [NUM_SRC];
  hazHits_t         hits;
  hazStrobes_t      strobes;

  assign exSrc[0] = exRs;
  assign exSrc[1] = exRt;
  assign idSrc[0] = idRs;
  assign idSrc[1] = idRt;

  hazard_fwd_path #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .exSrc      (exSrc),
    .idSrc      (idSrc),
    .loadDst    (exRt),
    .memRegWrite(memRegWrite),
    .memRd      (memRd),
    .wbRegWrite (wbRegWrite),
    .wbRd       (wbRd),
    .fwdSel     (selArr),
    .hits       (hits)
  );

  hazard_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .hits         (hits),
    .exMemRead    (exMemRead),
    .exBranchTaken(exBranchTaken),
    .strobes      (strobes)
  );

  assign fwdSelA    = selArr[0];
  assign fwdSelB    = selArr[1];
  assign holdFront  = strobes.holdFront;
  assign idExBubble = strobes.bubble;
  assign ifIdFlush  = strobes.flush;

endmodule

// File: tb/pipe_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe_hazard_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] idRs, idRt, exRs, exRt, memRd, wbRd;
  logic exMemRead, exBranchTaken, memRegWrite, wbRegWrite;
  logic [1:0] fwdSelA, fwdSelB;
  logic holdFront, idExBubble, ifIdFlush;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pipe_hazard_unit u_pipe_hazard_unit (
    .clk(clk), .rstN(rstN), .idRs(idRs), .idRt(idRt), .exRs(exRs), .exRt(exRt),
    .exMemRead(exMemRead), .exBranchTaken(exBranchTaken),
    .memRegWrite(memRegWrite), .memRd(memRd), .wbRegWrite(wbRegWrite), .wbRd(wbRd),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .holdFront(holdFront),
    .idExBubble(idExBubble), .ifIdFlush(ifIdFlush)
  );

  // behavioural reference: integers only
  function automatic int refSel(int src, int mw, int md, int ww, int wd);
    if (mw != 0 && md != 0 && md == src) return 2;
    if (ww != 0 && wd != 0 && wd == src) return 1;
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int eA, eB, eHold, eFlush, eBub;
    eA = refSel(int'(exRs), int'(memRegWrite), int'(memRd), int'(wbRegWrite), int'(wbRd));
    eB = refSel(int'(exRt), int'(memRegWrite), int'(memRd), int'(wbRegWrite), int'(wbRd));
    eFlush = int'(exBranchTaken);
    eHold = (!exBranchTaken && exMemRead && (exRt == idRs || exRt == idRt)) ? 1 : 0;
    eBub = (eFlush != 0 || eHold != 0) ? 1 : 0;
    cmp(tag, "fwdSelA", int'(fwdSelA), eA);
    cmp(tag, "fwdSelB", int'(fwdSelB), eB);
    cmp(tag, "holdFront", int'(holdFront), eHold);
    cmp(tag, "idExBubble", int'(idExBubble), eBub);
    cmp(tag, "ifIdFlush", int'(ifIdFlush), eFlush);
  endtask

  task automatic apply(int iRs, int iRt, int xRs, int xRt, int mr, int br,
                       int mw, int md, int ww, int wd, string tag);
    @(negedge clk);
    idRs = 5'(iRs); idRt = 5'(iRt); exRs = 5'(xRs); exRt = 5'(xRt);
    exMemRead = (mr != 0); exBranchTaken = (br != 0);
    memRegWrite = (mw != 0); memRd = 5'(md);
    wbRegWrite = (ww != 0); wbRd = 5'(wd);
    #1 checkAll(tag);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idRs = '0; idRt = '0; exRs = '0; exRt = '0; memRd = '0; wbRd = '0;
    exMemRead = 0; exBranchTaken = 0; memRegWrite = 0; wbRegWrite = 0;
    repeat (2) @(negedge clk);
    #1 checkAll("R5 reset");
    @(negedge clk); rstN = 1'b1;

    //     iRs iRt xRs xRt mr br mw md ww wd
    apply(1, 2, 3, 9, 0, 0, 1, 3, 0, 0, "R1 operand A from memory stage");
    apply(1, 2, 8, 4, 0, 0, 1, 4, 0, 0, "R1 operand B from memory stage");
    apply(1, 2, 3, 9, 0, 0, 0, 0, 1, 3, "R2 operand A from write-back");
    apply(1, 2, 8, 6, 0, 0, 1, 7, 1, 6, "R2 operand B from write-back");
    apply(1, 2, 3, 3, 0, 0, 1, 3, 1, 3, "R3 memory stage wins");
    apply(1, 2, 0, 0, 0, 0, 1, 0, 1, 0, "R4 register zero");
    apply(1, 2, 5, 5, 0, 0, 0, 5, 0, 5, "R4 write enables low");
    apply(1, 2, 5, 6, 0, 0, 1, 7, 1, 8, "R5 no match");
    apply(1, 2, 5, 6, 0, 0, 1, 5, 1, 6, "R10 independent operands");
    apply(7, 2, 1, 7, 1, 0, 0, 0, 0, 0, "R6 load-use on rs");
    apply(3, 7, 1, 7, 1, 0, 0, 0, 0, 0, "R6 load-use on rt");
    apply(3, 4, 1, 7, 1, 0, 0, 0, 0, 0, "R6 load without dependence");
    apply(7, 7, 1, 7, 0, 0, 1, 7, 0, 0, "R7 ALU producer no stall");
    apply(1, 2, 3, 4, 0, 1, 0, 0, 0, 0, "R8 taken branch");
    apply(7, 2, 1, 7, 1, 1, 0, 0, 0, 0, "R9 flush over stall");

    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0) ? 1 : 0,
            int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            "R10 random mix");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule